// File: doc/BRIEF.md
# Two-Phase Framed Serial Transmitter

This block turns parallel words into a single serial data line, one bit per bit clock. A frame-sync input marks where each frame begins. A programmable data delay of zero, one or two bit clocks sets where the first bit lands relative to that pulse. A frame is built from either one phase or two. Each phase has its own word count and word length, so a frame can carry, for example, two 16-bit words followed by ten 8-bit words. Bits leave most-significant first.

Words enter through a valid/ready interface backed by a one-entry holding register. The line is driven only while a frame is being sent. Three status strobes accompany the serial data: one marks the first bit of a frame, one marks the last bit of a frame, and one marks a word that had to be repeated because no new word was waiting.

When the next frame sync lands at the right point near the end of the current frame, frames follow one another with no idle clock between them. Once the stream is running, any frame sync that arrives in the middle of a frame is discarded.

Top module: `framed_tx`

## Requirements
- R1: After reset the drive-enable, the serial data and all three status strobes are low, and the word interface is ready.
- R2: Each word is sent most-significant first, using only its low L bits. The length select encodes L as follows: 0 is 8, 1 is 12, 2 is 16, 3 is 20, 4 is 24, and 5, 6 or 7 is 32.
- R3: The word-count fields hold the count minus one, so 0 to 127 means 1 to 128 words. With the two-phase flag high, the phase A words are followed by the phase B words inside one frame. With the flag low, a frame holds phase A only.
- R4: Delay code 1: a frame sync seen while idle puts the first bit on the line in the following cycle.
- R5: Delay code 2: the first bit appears two cycles after the frame sync. Code 3 behaves exactly like code 2.
- R6: Delay code 0: the first bit is on the line in the same cycle as the frame sync.
- R7: Within a frame, one bit goes out on every clock, and drive-enable stays high from the first bit to the last.
- R8: Frames run back to back with no idle clock when the next sync arrives at the right point: on the final bit for delay 1, on the clock after the final bit for delay 0, and on the second-to-last bit for delay 2.
- R9: A frame sync that arrives during a frame, outside that acceptance point, neither restarts nor lengthens the frame.
- R10: frame_start is high exactly in the cycle of a frame's first bit, and frame_end is high exactly in the cycle of its last bit.
- R11: If no fresh word is held when a word must begin, the previously sent word is sent again, and underrun is high during that word's first bit.
- R12: While drive-enable is low, the serial data and all three strobes are low.
- R13: word_ready is high exactly when the holding register is empty. A word is taken on a cycle where word_valid and word_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_two_phase | input | 1 | Frame carries phase B after phase A |
| cfg_a_len | input | 3 | Phase A word-length select |
| cfg_b_len | input | 3 | Phase B word-length select |
| cfg_a_words | input | CNT_W | Phase A word count minus one |
| cfg_b_words | input | CNT_W | Phase B word count minus one |
| cfg_delay | input | 2 | Data delay code |
| fsync | input | 1 | Frame-sync pulse |
| word_data | input | 32 | Parallel word, right-aligned |
| word_valid | input | 1 | word_data is offered |
| word_ready | output | 1 | Holding register empty |
| sdata | output | 1 | Serial data bit |
| sdata_en | output | 1 | Drive-enable for the serial line |
| frame_start | output | 1 | First bit of a frame |
| frame_end | output | 1 | Last bit of a frame |
| underrun | output | 1 | Current word is a repeat |

## Verification
The hardest cases to reach are the back-to-back joins, because the sync has to land on one exact bit of the running frame. That bit differs with the delay: the final bit, the clock after it, or the one before it. The stimulus places the sync at cycles computed from the frame length and the delay. It then checks that the combined bit stream has no hole and carries exactly two frame_start strobes. Underrun is reached by offering fewer words than the frame needs, and a mid-frame sync is injected to show that it is discarded.

// File: rtl/framed_tx_pkg.sv
package framed_tx_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W) + 1;

  // Word-length select to bit count
  function automatic logic [LEN_W-1:0] len_of(input logic [2:0] sel);
    case (sel)
      3'd0:    len_of = LEN_W'(8);
      3'd1:    len_of = LEN_W'(12);
      3'd2:    len_of = LEN_W'(16);
      3'd3:    len_of = LEN_W'(20);
      3'd4:    len_of = LEN_W'(24);
      default: len_of = LEN_W'(32);
    endcase
  endfunction

  // Move the word's MSB (bit len-1) up to bit WORD_W-1
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] w,
                                                  input logic [LEN_W-1:0] len);
    align_msb = w << (LEN_W'(WORD_W) - len);
  endfunction
endpackage

// File: rtl/framed_tx_wordbuf.sv
module framed_tx_wordbuf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         consume,
  output logic [W-1:0] held,
  output logic         held_fresh
);
  logic         fresh_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_ready   = !fresh_q;
  assign take       = in_valid && !fresh_q;
  assign held       = data_q;
  assign held_fresh = fresh_q;

  // data_q keeps the last word taken, so a repeat after underrun sends it again
  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (take) data_q <= in_data;
      fresh_q <= take || (fresh_q && !consume);
    end
  end
endmodule

// File: rtl/framed_tx_sync.sv
module framed_tx_sync (
  input  logic       clk,
  input  logic       rst,
  input  logic       fsync,
  input  logic [1:0] dly,
  input  logic       busy,
  input  logic       on_last,
  input  logic       on_slast,
  output logic       zstart,
  output logic       launch
);
  logic pend_q;
  logic accept;
  logic window;

  // Where inside a running frame a new sync may be taken
  always_comb begin
    case (dly)
      2'd0:    window = 1'b0;
      2'd1:    window = on_last;
      default: window = on_last || on_slast;
    endcase
  end

  assign accept = fsync && !pend_q && (!busy || window);
  assign zstart = accept && (dly == 2'd0);
  assign launch = (accept && (dly == 2'd1)) || pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= accept && dly[1];
  end
endmodule

// File: rtl/framed_tx_shifter.sv
module framed_tx_shifter
  import framed_tx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              two_phase,
  input  logic [2:0]        a_len_sel,
  input  logic [2:0]        b_len_sel,
  input  logic [CNT_W-1:0]  a_cnt_m1,
  input  logic [CNT_W-1:0]  b_cnt_m1,
  input  logic              zstart,
  input  logic              launch,
  input  logic [WORD_W-1:0] held,
  input  logic              held_fresh,
  output logic              consume,
  output logic              busy,
  output logic              on_last,
  output logic              on_slast,
  output logic              sdata,
  output logic              sdata_en,
  output logic              frame_start,
  output logic              frame_end,
  output logic              underrun
);
  localparam int WC_W = CNT_W + 1;

  logic              act_q, ph_q, first_q, unr_q;
  logic [WORD_W-1:0] sh_q;
  logic [LEN_W-1:0]  bl_q;
  logic [WC_W-1:0]   wl_q;

  logic [LEN_W-1:0]  a_len, b_len, nxt_len, v_bl;
  logic [WC_W-1:0]   a_wl, b_wl, nxt_wl, v_wl;
  logic [WORD_W-1:0] v_sh;
  logic              v_act, v_ph, v_first, v_unr, nxt_ph;
  logic              v_lastword, word_done, q_lastword;

  assign a_len = len_of(a_len_sel);
  assign b_len = len_of(b_len_sel);
  assign a_wl  = WC_W'(a_cnt_m1) + WC_W'(1);
  assign b_wl  = WC_W'(b_cnt_m1) + WC_W'(1);

  // View of the bit on the line this cycle: the registers, or a word
  // starting right now when the delay is zero
  always_comb begin
    if (act_q) begin
      v_act = 1'b1;     v_sh = sh_q;   v_bl = bl_q;  v_wl = wl_q;
      v_ph  = ph_q;     v_first = first_q;           v_unr = unr_q;
    end else begin
      v_act = zstart;   v_sh = align_msb(held, a_len);
      v_bl  = a_len;    v_wl = a_wl;   v_ph = 1'b0;
      v_first = 1'b1;   v_unr = !held_fresh;
    end
  end

  assign v_lastword = (v_wl == WC_W'(1)) && (v_ph || !two_phase);
  assign word_done  = v_act && (v_bl == LEN_W'(1));

  // Next word in the frame: same phase while words remain, else phase B
  always_comb begin
    if (v_wl != WC_W'(1)) begin
      nxt_len = v_ph ? b_len : a_len;
      nxt_wl  = v_wl - WC_W'(1);
      nxt_ph  = v_ph;
    end else begin
      nxt_len = b_len;
      nxt_wl  = b_wl;
      nxt_ph  = 1'b1;
    end
  end

  assign consume = launch || zstart || (word_done && !v_lastword);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;  sh_q <= '0;  bl_q <= '0;  wl_q <= '0;
      ph_q  <= 1'b0;  first_q <= 1'b0;  unr_q <= 1'b0;
    end else if (launch) begin
      act_q <= 1'b1;  sh_q <= align_msb(held, a_len);
      bl_q  <= a_len; wl_q <= a_wl;  ph_q <= 1'b0;
      first_q <= 1'b1;  unr_q <= !held_fresh;
    end else if (v_act && !word_done) begin
      act_q <= 1'b1;  sh_q <= v_sh << 1;
      bl_q  <= v_bl - LEN_W'(1);  wl_q <= v_wl;  ph_q <= v_ph;
      first_q <= 1'b0;  unr_q <= 1'b0;
    end else if (word_done && !v_lastword) begin
      act_q <= 1'b1;  sh_q <= align_msb(held, nxt_len);
      bl_q  <= nxt_len;  wl_q <= nxt_wl;  ph_q <= nxt_ph;
      first_q <= 1'b0;  unr_q <= !held_fresh;
    end else begin
      act_q <= 1'b0;
    end
  end

  assign q_lastword = (wl_q == WC_W'(1)) && (ph_q || !two_phase);
  assign busy       = act_q;
  assign on_last    = act_q && q_lastword && (bl_q == LEN_W'(1));
  assign on_slast   = act_q && q_lastword && (bl_q == LEN_W'(2));

  assign sdata       = v_act && v_sh[WORD_W-1];
  assign sdata_en    = v_act;
  assign frame_start = v_act && v_first;
  assign frame_end   = word_done && v_lastword;
  assign underrun    = v_act && v_unr;
endmodule

// File: rtl/framed_tx.sv
module framed_tx
  import framed_tx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_two_phase,
  input  logic [2:0]        cfg_a_len,
  input  logic [2:0]        cfg_b_len,
  input  logic [CNT_W-1:0]  cfg_a_words,
  input  logic [CNT_W-1:0]  cfg_b_words,
  input  logic [1:0]        cfg_delay,
  input  logic              fsync,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              sdata,
  output logic              sdata_en,
  output logic              frame_start,
  output logic              frame_end,
  output logic              underrun
);
  logic [WORD_W-1:0] held;
  logic held_fresh, consume, busy, on_last, on_slast, zstart, launch;

  framed_tx_wordbuf #(.W(WORD_W)) u_buf (
    .clk(clk), .rst(rst), .in_data(word_data), .in_valid(word_valid),
    .in_ready(word_ready), .consume(consume), .held(held),
    .held_fresh(held_fresh)
  );

  framed_tx_sync u_sync (
    .clk(clk), .rst(rst), .fsync(fsync), .dly(cfg_delay), .busy(busy),
    .on_last(on_last), .on_slast(on_slast), .zstart(zstart), .launch(launch)
  );

  framed_tx_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .two_phase(cfg_two_phase),
    .a_len_sel(cfg_a_len), .b_len_sel(cfg_b_len),
    .a_cnt_m1(cfg_a_words), .b_cnt_m1(cfg_b_words),
    .zstart(zstart), .launch(launch), .held(held), .held_fresh(held_fresh),
    .consume(consume), .busy(busy), .on_last(on_last), .on_slast(on_slast),
    .sdata(sdata), .sdata_en(sdata_en), .frame_start(frame_start),
    .frame_end(frame_end), .underrun(underrun)
  );
endmodule

// File: rtl/framed_tx_chk.sv
module framed_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_delay,
  input logic       fsync,
  input logic       word_valid,
  input logic       word_ready,
  input logic       sdata,
  input logic       sdata_en,
  input logic       frame_start,
  input logic       frame_end,
  input logic       underrun
);
  // R10
  start_en_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> sdata_en);
  // R11
  underrun_en_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> sdata_en);
  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (sdata_en && !frame_end) |=> sdata_en);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (sdata_en && !frame_end) |=> !frame_start);
  // R8
  stream_d1_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_delay == 2'd1 && fsync && frame_end) |=> frame_start);
  // R4
  idle_d1_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_delay == 2'd1 && fsync && !sdata_en) |=> frame_start);
  // R6
  zero_dly_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_delay == 2'd0 && fsync && $past(!sdata_en || frame_end)) |-> frame_start);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sdata_en |-> !(sdata || frame_start || frame_end || underrun));
  // R13
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_ready && !word_valid) |=> word_ready);
endmodule

bind framed_tx framed_tx_chk u_chk (
  .clk(clk), .rst(rst), .cfg_delay(cfg_delay), .fsync(fsync),
  .word_valid(word_valid), .word_ready(word_ready), .sdata(sdata),
  .sdata_en(sdata_en), .frame_start(frame_start), .frame_end(frame_end),
  .underrun(underrun)
);

// File: tb/framed_tx_test.sv
`timescale 1ns/1ps
module framed_tx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_two_phase = 1'b0;
  logic [2:0] cfg_a_len = '0, cfg_b_len = '0;
  logic [6:0] cfg_a_words = '0, cfg_b_words = '0;
  logic [1:0] cfg_delay = '0;
  logic fsync = 1'b0;
  logic [31:0] word_data = '0;
  logic word_valid = 1'b0;
  logic word_ready, sdata, sdata_en, frame_start, frame_end, underrun;

  always #2 clk = ~clk;

  framed_tx uut (
    .clk(clk), .rst(rst), .cfg_two_phase(cfg_two_phase),
    .cfg_a_len(cfg_a_len), .cfg_b_len(cfg_b_len),
    .cfg_a_words(cfg_a_words), .cfg_b_words(cfg_b_words),
    .cfg_delay(cfg_delay), .fsync(fsync), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .sdata(sdata),
    .sdata_en(sdata_en), .frame_start(frame_start), .frame_end(frame_end),
    .underrun(underrun)
  );

  int tests = 0, fails = 0;
  logic [31:0] feed [0:15];
  int feed_n;
  int fs_a, fs_b, fs_c;
  logic exp_bits [0:255];
  int exp_n;
  logic rec_en [0:127], rec_bit [0:127], rec_fs [0:127], rec_fe [0:127], rec_un [0:127];

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fsync = 1'b0; word_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic add_word(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      exp_bits[exp_n] = w[i];
      exp_n++;
    end
  endtask

  task automatic run(input int ncyc);
    int fi;
    fi = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      fsync = (c == fs_a) || (c == fs_b) || (c == fs_c);
      word_valid = (fi < feed_n);
      word_data = (fi < feed_n) ? feed[fi] : 32'h0;
      #1;
      rec_en[c] = sdata_en; rec_bit[c] = sdata;
      rec_fs[c] = frame_start; rec_fe[c] = frame_end; rec_un[c] = underrun;
      if (word_valid && word_ready) fi++;
    end
    @(negedge clk);
    fsync = 1'b0; word_valid = 1'b0;
  endtask

  task automatic check_stream(input string req, input int first);
    int bad, badc;
    bad = 0; badc = -1;
    if (rec_en[first-1]) begin bad++; badc = first - 1; end
    for (int i = 0; i < exp_n; i++)
      if (!rec_en[first+i] || rec_bit[first+i] != exp_bits[i]) begin
        if (badc < 0) badc = first + i;
        bad++;
      end
    if (rec_en[first+exp_n]) begin bad++; if (badc < 0) badc = first + exp_n; end
    check(req, $sformatf("stream mismatches (first bad cycle %0d)", badc), bad, 0);
  endtask

  function automatic int count_of(input int which, input int ncyc);
    int n;
    n = 0;
    for (int c = 0; c < ncyc; c++)
      n += (which == 0) ? int'(rec_fs[c]) : (which == 1) ? int'(rec_fe[c]) : int'(rec_un[c]);
    return n;
  endfunction

  task automatic setup(input logic two, input logic [2:0] al, input logic [2:0] bl,
                       input int aw, input int bw, input logic [1:0] d);
    do_reset();
    cfg_two_phase = two; cfg_a_len = al; cfg_b_len = bl;
    cfg_a_words = 7'(aw - 1); cfg_b_words = 7'(bw - 1); cfg_delay = d;
    fs_a = -1; fs_b = -1; fs_c = -1; exp_n = 0; feed_n = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1", "sdata_en", int'(sdata_en), 0);
    check("R1", "strobes|sdata", int'(frame_start | frame_end | underrun | sdata), 0);
    check("R1", "word_ready", int'(word_ready), 1);
  endtask

  task automatic t_basic_d1();
    setup(1'b0, 3'd0, 3'd0, 2, 1, 2'd1);
    feed[0] = 32'hA5; feed[1] = 32'h3C; feed_n = 2; fs_a = 2;
    add_word(32'hA5, 8); add_word(32'h3C, 8);
    run(30);
    check_stream("R4", 3);
    check("R10", "frame_start@3", int'(rec_fs[3]), 1);
    check("R10", "frame_end@18", int'(rec_fe[18]), 1);
    check("R10", "frame_start count", count_of(0, 30), 1);
    check("R12", "strobes idle@25", int'(rec_fs[25] | rec_fe[25] | rec_bit[25]), 0);
  endtask

  task automatic t_two_phase();
    setup(1'b1, 3'd2, 3'd0, 2, 3, 2'd1);
    feed[0] = 32'hBEEF; feed[1] = 32'h1234; feed[2] = 32'h81;
    feed[3] = 32'h7E; feed[4] = 32'h0F; feed_n = 5; fs_a = 2;
    add_word(32'hBEEF, 16); add_word(32'h1234, 16);
    add_word(32'h81, 8); add_word(32'h7E, 8); add_word(32'h0F, 8);
    run(70);
    check_stream("R3", 3);
    check("R3", "frame_end@58", int'(rec_fe[58]), 1);
  endtask

  task automatic t_lengths();
    setup(1'b1, 3'd1, 3'd3, 1, 1, 2'd1);
    feed[0] = 32'hFFFF_FABC; feed[1] = 32'h1234_5678; feed_n = 2; fs_a = 2;
    add_word(32'hABC, 12); add_word(32'h45678, 20);
    run(45);
    check_stream("R2", 3);
    setup(1'b1, 3'd4, 3'd5, 1, 1, 2'd1);
    feed[0] = 32'hDDC0_FFEE; feed[1] = 32'h89AB_CDEF; feed_n = 2; fs_a = 2;
    add_word(32'hC0FFEE, 24); add_word(32'h89ABCDEF, 32);
    run(70);
    check_stream("R2", 3);
  endtask

  task automatic t_delay0();
    setup(1'b0, 3'd0, 3'd0, 2, 1, 2'd0);
    for (int i = 0; i < 4; i++) feed[i] = 32'h11 * (i + 3);
    feed_n = 4; fs_a = 2; fs_b = 18;
    for (int i = 0; i < 4; i++) add_word(32'h11 * (i + 3), 8);
    run(45);
    check_stream("R6", 2);
    check("R8", "frame_start@18 (delay 0 join)", int'(rec_fs[18]), 1);
  endtask

  task automatic t_delay2();
    setup(1'b0, 3'd0, 3'd0, 2, 1, 2'd2);
    for (int i = 0; i < 4; i++) feed[i] = 32'h5A ^ (32'h0F * i);
    feed_n = 4; fs_a = 2; fs_b = 18;
    for (int i = 0; i < 4; i++) add_word(32'h5A ^ (32'h0F * i), 8);
    run(45);
    check_stream("R5", 4);
    check("R8", "frame_start count delay 2", count_of(0, 45), 2);
    setup(1'b0, 3'd0, 3'd0, 1, 1, 2'd3);
    feed[0] = 32'hC3; feed_n = 1; fs_a = 2;
    add_word(32'hC3, 8);
    run(20);
    check_stream("R5", 4);
  endtask

  task automatic t_stream_d1();
    setup(1'b0, 3'd0, 3'd0, 2, 1, 2'd1);
    for (int i = 0; i < 4; i++) feed[i] = 32'h96 + i;
    feed_n = 4; fs_a = 2; fs_b = 18;
    for (int i = 0; i < 4; i++) add_word(32'h96 + i, 8);
    run(45);
    check_stream("R8", 3);
    check("R7", "frame_start@19", int'(rec_fs[19]), 1);
  endtask

  task automatic t_ignore();
    setup(1'b0, 3'd0, 3'd0, 2, 1, 2'd1);
    feed[0] = 32'hF0; feed[1] = 32'h0D; feed_n = 2; fs_a = 2; fs_b = 8; fs_c = 12;
    add_word(32'hF0, 8); add_word(32'h0D, 8);
    run(30);
    check_stream("R9", 3);
    check("R9", "frame_start count", count_of(0, 30), 1);
  endtask

  task automatic t_underrun();
    setup(1'b0, 3'd0, 3'd0, 2, 1, 2'd1);
    feed[0] = 32'hA5; feed_n = 1; fs_a = 2;
    add_word(32'hA5, 8); add_word(32'hA5, 8);
    run(30);
    check_stream("R11", 3);
    check("R11", "underrun@11", int'(rec_un[11]), 1);
    check("R11", "underrun count", count_of(2, 30), 1);
    check("R13", "ready after drain", int'(word_ready), 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_d1();
    t_two_phase();
    t_lengths();
    t_delay0();
    t_delay2();
    t_stream_d1();
    t_ignore();
    t_underrun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule